// File: doc/BRIEF.md
# Ownership-Tracking Snoop Cache Controller

This block controls a direct-mapped private cache in a bus-connected multiprocessor. Every line carries one of four coherence states. Two of those states mark the cache as the line's owner, and the owner is the only cache obliged to put the line back into memory. The controller serves a processor request port and acts as a master on a shared bus that carries reads, address-only invalidations and write-backs. It also watches the bus traffic of the other caches through a second lookup into its own directory. This second lookup works alongside processor accesses.

When another cache reads a line that this cache owns, the controller supplies the data itself. In the same cycle it raises a memory-inhibit output so that memory stays off the data lines. A copy that does not carry ownership may hold data that differs from memory, but it is dropped on eviction and never written back. A configuration input turns on read broadcast. With it on, data seen on the bus for some other cache's read refills a local copy of that same line that had been invalidated.

Bus arbitration and the memory controller sit outside the block. Each bus transaction completes in the cycle in which the grant is high, and read data is valid in that cycle. No snooped transaction is presented in a cycle that carries this cache's own grant.

Top module: `mosi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_done`, `bus_req` and `snp_inhibit` are low, and the first processor read of any address issues a bus read.
- R2: A processor read miss issues a bus read (`bus_cmd` = 1) for the request address. The returned data is delivered on `cpu_rdata` with `cpu_done` in the cycle after the grant, and the line becomes unowned-shared: later reads of it hit with no bus transaction.
- R3: A processor write to a line held unowned-shared or owned-shared issues one address-only invalidation (`bus_cmd` = 2), then holds the line owned-exclusive with the written data.
- R4: A snooped read (`snp_cmd` = 1) that hits an owned-exclusive line drives `snp_inhibit` high and the line's data on `snp_sdata` in the same cycle. The line then becomes owned-shared, so it keeps answering later snooped reads and a later processor write to it needs an invalidation.
- R5: Evicting an unowned-shared line is silent, even when its data came from another cache and not from memory: only the bus read for the new line is issued.
- R6: With `rd_bcast_en` high, a snooped read whose address matches the tag of a locally invalid line fills that line with `snp_data` as unowned-shared. With `rd_bcast_en` low, or when the tag differs, the line stays invalid.
- R7: Evicting a line in either owned state issues a write-back (`bus_cmd` = 3) carrying the victim's address and data, and the bus read for the new line follows directly after it.
- R8: A snooped invalidation (`snp_cmd` = 2) that hits a line makes it invalid in any state: later snooped reads of it are not inhibited, and the next processor read issues a bus read with no write-back.
- R9: `snp_inhibit` is high only during a snooped read that hits an owned line. Unowned-shared and invalid lines never inhibit.
- R10: A processor write hit on an owned-exclusive line finishes with no bus transaction, and `cpu_done` lasts exactly one cycle.
- R11: A processor write miss issues a bus read and then an invalidation for the same address before `cpu_done`, and leaves the line owned-exclusive with the written data.
- R12: If a snooped invalidation removes the line while the controller is still waiting to invalidate for a processor write, the controller withdraws the invalidation, fetches the line again and only then invalidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_bcast_en | input | 1 | Enables refilling invalid copies from snooped read data |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: low IDX_W bits index, rest tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for a bus transaction |
| bus_cmd | output | 2 | 1 read, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Read data in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Data on the bus during a snooped read |
| snp_inhibit | output | 1 | This cache supplies the data; memory stays silent |
| snp_sdata | output | DATA_W | Data supplied to the requesting cache |

## Verification
The bench follows one line through every ownership change: filled as unowned, written to exclusive ownership, downgraded by a snooped read, and written again. A controller that moved to the wrong state would show up in one of three ways: a missing or extra invalidation, an inhibit that stops after the first snooped read, or an inhibit raised for a non-owner. Evictions are tested from both an owned and an unowned line. A design that wrote back unowned data, or dropped owned data, would show a wrong sequence of bus commands. Read broadcast is tested enabled, disabled and with a tag mismatch, so a fill that ignored the enable or the tag would turn a later miss into a hit. The last test lets a snooped invalidation arrive while an invalidation of the bench's own is still pending. A design that forgot the lost copy would claim ownership of stale data without fetching it again.

// File: rtl/mosi_pkg.sv
package mosi_pkg;

    typedef enum logic [1:0] {
        L_INV = 2'd0,
        L_US  = 2'd1,
        L_OS  = 2'd2,
        L_OE  = 2'd3
    } lstate_e;

    typedef enum logic [1:0] {
        C_NONE = 2'd0,
        C_READ = 2'd1,
        C_INV  = 2'd2,
        C_WB   = 2'd3
    } bcmd_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_WB,
        F_FILL,
        F_INV,
        F_RESP
    } fsm_e;

    function automatic logic is_owner(lstate_e s);
        return (s == L_OS) || (s == L_OE);
    endfunction

endpackage

// File: rtl/mosi_lookup.sv
module mosi_lookup
    import mosi_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    localparam int LINES = 1 << IDX_W
) (
    input  lstate_e [LINES-1:0]             st_arr,
    input  logic    [LINES-1:0][TAG_W-1:0]  tag_arr,
    input  logic    [LINES-1:0][DATA_W-1:0] dat_arr,
    input  logic    [IDX_W-1:0]             idx,
    input  logic    [TAG_W-1:0]             tag,
    output lstate_e                         st,
    output logic    [TAG_W-1:0]             line_tag,
    output logic    [DATA_W-1:0]            data,
    output logic                            tag_eq,
    output logic                            hit
);
    always_comb begin
        st       = st_arr[idx];
        line_tag = tag_arr[idx];
        data     = dat_arr[idx];
        tag_eq   = (line_tag == tag);
        hit      = tag_eq && (st != L_INV);
    end
endmodule

// File: rtl/mosi_snoop_policy.sv
module mosi_snoop_policy
    import mosi_pkg::*;
(
    input  logic    valid,
    input  bcmd_e   cmd,
    input  logic    rb_en,
    input  logic    tag_eq,
    input  lstate_e cur,
    output lstate_e nxt,
    output logic    load,
    output logic    inhibit
);
    logic present;

    always_comb begin
        present = tag_eq && (cur != L_INV);
        nxt     = cur;
        load    = 1'b0;
        inhibit = 1'b0;
        if (valid) begin
            unique case (cmd)
                C_READ: begin
                    if (present && is_owner(cur)) begin
                        inhibit = 1'b1;
                        nxt     = L_OS;
                    end else if (rb_en && tag_eq && cur == L_INV) begin
                        nxt  = L_US;
                        load = 1'b1;
                    end
                end
                C_INV: begin
                    if (present) nxt = L_INV;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mosi_snoop_ctrl.sv
module mosi_snoop_ctrl
    import mosi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_bcast_en,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_inhibit,
    output logic [DATA_W-1:0] snp_sdata
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        fsm_e                              fsm;
        logic                              done;
        logic    [DATA_W-1:0]              rdata;
        lstate_e [LINES-1:0]               st;
        logic    [LINES-1:0][TAG_W-1:0]    tag;
        logic    [LINES-1:0][DATA_W-1:0]   dat;
    } regs_t;

    regs_t r_d, r_q;

    // processor-side directory port
    logic [IDX_W-1:0]  c_idx;
    logic [TAG_W-1:0]  c_tag;
    lstate_e           c_st;
    logic [TAG_W-1:0]  c_ltag;
    logic [DATA_W-1:0] c_data;
    logic              c_teq, c_hit, c_owned;

    assign c_idx   = cpu_addr[IDX_W-1:0];
    assign c_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign c_owned = is_owner(c_st);

    mosi_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu_look (
        .st_arr(r_q.st), .tag_arr(r_q.tag), .dat_arr(r_q.dat),
        .idx(c_idx), .tag(c_tag),
        .st(c_st), .line_tag(c_ltag), .data(c_data), .tag_eq(c_teq), .hit(c_hit)
    );

    // bus-side directory port
    logic [IDX_W-1:0]  s_idx;
    logic [TAG_W-1:0]  s_tag;
    lstate_e           s_st, sp_nxt;
    logic [TAG_W-1:0]  s_ltag;
    logic [DATA_W-1:0] s_data;
    logic              s_teq, s_hit, sp_load, sp_inh;

    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    mosi_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp_look (
        .st_arr(r_q.st), .tag_arr(r_q.tag), .dat_arr(r_q.dat),
        .idx(s_idx), .tag(s_tag),
        .st(s_st), .line_tag(s_ltag), .data(s_data), .tag_eq(s_teq), .hit(s_hit)
    );

    mosi_snoop_policy u_policy (
        .valid(snp_valid), .cmd(bcmd_e'(snp_cmd)), .rb_en(rd_bcast_en),
        .tag_eq(s_teq), .cur(s_st),
        .nxt(sp_nxt), .load(sp_load), .inhibit(sp_inh)
    );

    assign snp_inhibit = sp_inh;
    assign snp_sdata   = s_data;
    assign cpu_done    = r_q.done;
    assign cpu_rdata   = r_q.rdata;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = C_NONE;
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;

        // snooped transaction updates the addressed line
        r_d.st[s_idx] = sp_nxt;
        if (sp_load) r_d.dat[s_idx] = snp_data;

        // processor request sequencing
        unique case (r_q.fsm)
            F_IDLE: begin
                if (cpu_req && !snp_valid) begin
                    if (c_hit) begin
                        if (!cpu_we) begin
                            r_d.done  = 1'b1;
                            r_d.rdata = c_data;
                            r_d.fsm   = F_RESP;
                        end else if (c_st == L_OE) begin
                            r_d.dat[c_idx] = cpu_wdata;
                            r_d.done       = 1'b1;
                            r_d.fsm        = F_RESP;
                        end else begin
                            r_d.fsm = F_INV;
                        end
                    end else if (c_owned) begin
                        r_d.fsm = F_WB;
                    end else begin
                        r_d.fsm = F_FILL;
                    end
                end
            end
            F_WB: begin
                if (!c_owned) begin
                    r_d.fsm = F_FILL;
                end else begin
                    bus_req   = 1'b1;
                    bus_cmd   = C_WB;
                    bus_addr  = {c_ltag, c_idx};
                    bus_wdata = c_data;
                    if (bus_gnt) begin
                        r_d.st[c_idx] = L_INV;
                        r_d.fsm       = F_FILL;
                    end
                end
            end
            F_FILL: begin
                bus_req = 1'b1;
                bus_cmd = C_READ;
                if (bus_gnt) begin
                    r_d.tag[c_idx] = c_tag;
                    r_d.dat[c_idx] = bus_rdata;
                    r_d.st[c_idx]  = L_US;
                    if (cpu_we) begin
                        r_d.fsm = F_INV;
                    end else begin
                        r_d.done  = 1'b1;
                        r_d.rdata = bus_rdata;
                        r_d.fsm   = F_RESP;
                    end
                end
            end
            F_INV: begin
                if (!c_hit) begin
                    r_d.fsm = F_FILL;
                end else begin
                    bus_req = 1'b1;
                    bus_cmd = C_INV;
                    if (bus_gnt) begin
                        r_d.st[c_idx]  = L_OE;
                        r_d.dat[c_idx] = cpu_wdata;
                        r_d.done       = 1'b1;
                        r_d.fsm        = F_RESP;
                    end
                end
            end
            F_RESP: r_d.fsm = F_IDLE;
            default: r_d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.fsm   <= F_IDLE;
            r_q.done  <= 1'b0;
            r_q.rdata <= '0;
            r_q.st    <= {LINES{L_INV}};
            r_q.tag   <= '0;
            r_q.dat   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R9: inhibit only during a snooped read
    p_inhibit_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_inhibit |-> (snp_valid && snp_cmd == C_READ));

    // R7: a granted write-back is followed by the fetch of the new line
    p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == C_WB && bus_gnt) |=> (bus_req && bus_cmd == C_READ));

    // R2: read-miss data reaches the processor one cycle after the grant
    p_fill_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == C_READ && bus_gnt && !cpu_we)
        |=> (cpu_done && cpu_rdata == $past(bus_rdata)));

    // R3: a granted invalidation completes the write
    p_inv_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == C_INV && bus_gnt) |=> cpu_done);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R8: right after a snooped invalidation the same address is not owned here
    p_inv_drops_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == C_INV && !bus_gnt)
        |=> !(snp_valid && snp_cmd == C_READ && snp_addr == $past(snp_addr) && snp_inhibit));

endmodule

// File: tb/test_mosi_snoop_ctrl.sv
module test_mosi_snoop_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_bcast_en = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic          cpu_done, bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_gnt = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_inhibit;
    logic [DW-1:0] snp_sdata;

    always #10 clk = ~clk;   // 50 MHz

    mosi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(4), .DATA_W(DW)) i_mosi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_bcast_en(rd_bcast_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_data(snp_data), .snp_inhibit(snp_inhibit), .snp_sdata(snp_sdata)
    );

    localparam logic [1:0] RD = 2'd1, IV = 2'd2, WB = 2'd3;

    int n_chk = 0, n_bad = 0;
    int n_tx;
    logic [1:0]    tx_cmd  [8];
    logic [AW-1:0] tx_addr [8];
    logic [DW-1:0] tx_data [8];
    logic          done_seen;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // serve the bus until the processor request completes
    task automatic serve(input logic [DW-1:0] gd, output logic [DW-1:0] rd);
        done_seen = 1'b0;
        rd = '0;
        for (int i = 0; i < 40 && !done_seen; i++) begin
            @(negedge clk);
            #1;
            if (cpu_done) begin
                rd = cpu_rdata;
                done_seen = 1'b1;
                cpu_req = 1'b0;
                bus_gnt = 1'b0;
            end else if (bus_req) begin
                if (n_tx < 8) begin
                    tx_cmd[n_tx] = bus_cmd; tx_addr[n_tx] = bus_addr; tx_data[n_tx] = bus_wdata;
                end
                n_tx++;
                bus_gnt = 1'b1;
                bus_rdata = gd;
            end else begin
                bus_gnt = 1'b0;
            end
        end
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [DW-1:0] gd, output logic [DW-1:0] rd);
        n_tx = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        serve(gd, rd);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic inh, output logic [DW-1:0] sd);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_data = d;
        #1;
        inh = snp_inhibit;
        sd  = snp_sdata;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = '0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] rd;
        chk(!cpu_done && !bus_req && !snp_inhibit, "R1", "idle outputs after reset",
            {cpu_done, bus_req, snp_inhibit}, 0);
        cpu_op(1'b0, 8'h05, '0, 16'h0B0B, rd);
        chk(n_tx == 1 && tx_cmd[0] == RD, "R1", "first read goes to bus", n_tx, 1);
    endtask

    task automatic t_read_miss;
        logic [DW-1:0] rd, sd; logic inh;
        cpu_op(1'b0, 8'h13, '0, 16'hAAAA, rd);
        chk(n_tx == 1 && tx_cmd[0] == RD && tx_addr[0] == 8'h13, "R2", "miss issues read",
            {tx_cmd[0], tx_addr[0]}, {RD, 8'h13});
        chk(rd == 16'hAAAA, "R2", "miss data", rd, 16'hAAAA);
        cpu_op(1'b0, 8'h13, '0, 16'hDEAD, rd);
        chk(n_tx == 0 && rd == 16'hAAAA, "R2", "second read hits", rd, 16'hAAAA);
        snoop(RD, 8'h13, 16'h0, inh, sd);
        chk(!inh, "R9", "unowned line does not inhibit", inh, 0);
    endtask

    task automatic t_ownership;
        logic [DW-1:0] rd, sd; logic inh;
        cpu_op(1'b1, 8'h13, 16'h1111, 16'h0, rd);
        chk(n_tx == 1 && tx_cmd[0] == IV && tx_addr[0] == 8'h13, "R3", "write to US invalidates",
            tx_cmd[0], IV);
        cpu_op(1'b1, 8'h13, 16'h2222, 16'h0, rd);
        chk(n_tx == 0, "R10", "write hit on OE is silent", n_tx, 0);
        @(negedge clk); #1;
        chk(!cpu_done, "R10", "done lasts one cycle", cpu_done, 0);
        snoop(RD, 8'h13, 16'h0, inh, sd);
        chk(inh && sd == 16'h2222, "R4", "owner supplies data", {inh, sd}, {1'b1, 16'h2222});
        snoop(RD, 8'h13, 16'h0, inh, sd);
        chk(inh, "R4", "owned-shared keeps supplying", inh, 1);
        snoop(RD, 8'h93, 16'h0, inh, sd);
        chk(!inh, "R9", "tag mismatch does not inhibit", inh, 0);
        cpu_op(1'b1, 8'h13, 16'h3333, 16'h0, rd);
        chk(n_tx == 1 && tx_cmd[0] == IV, "R3", "write to OS invalidates", n_tx, 1);
    endtask

    task automatic t_evict;
        logic [DW-1:0] rd;
        cpu_op(1'b0, 8'h23, '0, 16'h4444, rd);
        chk(n_tx == 2 && tx_cmd[0] == WB && tx_addr[0] == 8'h13 && tx_data[0] == 16'h3333,
            "R7", "owned victim written back", {tx_cmd[0], tx_addr[0], tx_data[0]},
            {WB, 8'h13, 16'h3333});
        chk(tx_cmd[1] == RD && tx_addr[1] == 8'h23 && rd == 16'h4444, "R7", "fetch after write-back",
            {tx_cmd[1], rd}, {RD, 16'h4444});
        cpu_op(1'b0, 8'h33, '0, 16'h5555, rd);
        chk(n_tx == 1 && tx_cmd[0] == RD && tx_addr[0] == 8'h33, "R5", "unowned victim dropped",
            n_tx, 1);
    endtask

    task automatic t_snoop_inv;
        logic [DW-1:0] rd, sd; logic inh;
        snoop(IV, 8'h33, 16'h0, inh, sd);
        cpu_op(1'b0, 8'h33, '0, 16'h6666, rd);
        chk(n_tx == 1 && tx_cmd[0] == RD && rd == 16'h6666, "R8", "invalidated US refetched",
            n_tx, 1);
        cpu_op(1'b1, 8'h45, 16'h7777, 16'h0101, rd);
        chk(n_tx == 2 && tx_cmd[0] == RD && tx_cmd[1] == IV && tx_addr[1] == 8'h45, "R11",
            "write miss reads then invalidates", {tx_cmd[0], tx_cmd[1]}, {RD, IV});
        cpu_op(1'b0, 8'h45, '0, 16'h0, rd);
        chk(n_tx == 0 && rd == 16'h7777, "R11", "write miss leaves data", rd, 16'h7777);
        snoop(IV, 8'h45, 16'h0, inh, sd);
        snoop(RD, 8'h45, 16'h0, inh, sd);
        chk(!inh, "R8", "invalidated owner stops supplying", inh, 0);
        cpu_op(1'b0, 8'h45, '0, 16'h8888, rd);
        chk(n_tx == 1 && tx_cmd[0] == RD, "R8", "no write-back after invalidation", tx_cmd[0], RD);
    endtask

    task automatic t_bcast;
        logic [DW-1:0] rd, sd; logic inh;
        cpu_op(1'b0, 8'h57, '0, 16'h1234, rd);
        snoop(IV, 8'h57, 16'h0, inh, sd);
        rd_bcast_en = 1'b0;
        snoop(RD, 8'h57, 16'h5A5A, inh, sd);
        cpu_op(1'b0, 8'h57, '0, 16'h2345, rd);
        chk(n_tx == 1 && rd == 16'h2345, "R6", "broadcast off: no fill", n_tx, 1);
        snoop(IV, 8'h57, 16'h0, inh, sd);
        rd_bcast_en = 1'b1;
        snoop(RD, 8'h57, 16'h6B6B, inh, sd);
        chk(!inh, "R6", "refill does not inhibit", inh, 0);
        cpu_op(1'b0, 8'h57, '0, 16'hFFFF, rd);
        chk(n_tx == 0 && rd == 16'h6B6B, "R6", "broadcast fills invalid copy", rd, 16'h6B6B);
        cpu_op(1'b0, 8'h68, '0, 16'h3456, rd);
        snoop(IV, 8'h68, 16'h0, inh, sd);
        snoop(RD, 8'h78, 16'h7C7C, inh, sd);
        cpu_op(1'b0, 8'h68, '0, 16'h4567, rd);
        chk(n_tx == 1 && rd == 16'h4567, "R6", "tag mismatch not filled", rd, 16'h4567);
        rd_bcast_en = 1'b0;
    endtask

    task automatic t_race;
        logic [DW-1:0] rd;
        cpu_op(1'b0, 8'h9A, '0, 16'h1357, rd);
        n_tx = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h9A; cpu_wdata = 16'h2468;
        @(negedge clk); #1;
        chk(bus_req && bus_cmd == IV, "R12", "invalidation pending", {bus_req, bus_cmd}, {1'b1, IV});
        snp_valid = 1'b1; snp_cmd = IV; snp_addr = 8'h9A;
        @(negedge clk);
        snp_valid = 1'b0; snp_cmd = '0;
        #1;
        chk(!bus_req, "R12", "stale invalidation withdrawn", bus_req, 0);
        serve(16'h9999, rd);
        chk(n_tx == 2 && tx_cmd[0] == RD && tx_cmd[1] == IV, "R12", "refetch then invalidate",
            {tx_cmd[0], tx_cmd[1]}, {RD, IV});
        cpu_op(1'b0, 8'h9A, '0, 16'h0, rd);
        chk(n_tx == 0 && rd == 16'h2468, "R12", "written data kept", rd, 16'h2468);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_read_miss();
        t_ownership();
        t_evict();
        t_snoop_inv();
        t_bcast();
        t_race();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule